// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block is the host-side engine for the shared 8-bit I/O bus of a NAND flash device. One request carries an operation code, a column, a row and a data length. The block turns it into the series of bus cycles that the operation needs. It drives chip enable, the command-latch and address-latch strobes and the write strobe. Between the address and confirm cycles it pulls program data through a small valid/ready handshake. For operations that start an internal array action, it waits for the ready/busy pin to come back high.

Requests arrive through a ready/valid handshake. A request presented while the block is busy is held off and taken later, never lost. A request with an unknown operation code, or with a column past the end of the 2112-byte page, is answered with an error pulse and produces no bus activity.

Top module: `nand_cmd_seq`

## Requirements
- R1: Every bus cycle pulls `we_n` low for exactly max(`cfg_we_lo`,1) clocks while `ce_n` is low. `io_out`, `cle` and `ale` are stable for one clock before the falling edge, for the whole low phase, and for at least one clock after the rising edge.
- R2: `cle` is high only in command cycles and `ale` only in address cycles. Both are low in data cycles, and they are never high together.
- R3: Address bytes go out as column low, column high (column bits 11:8), row low, row high. Operation 0 sends 00h, four address bytes, 30h. Operation 1 sends 00h, four address bytes, 35h. Operation 2 sends 80h, four address bytes, data, 10h. Operation 3 sends 80h, four address bytes, data, 15h. Operation 4 sends 85h, four address bytes, data, 10h.
- R4: Operation 5 (erase) sends 60h, row low, row high, D0h, and nothing else. The column is not used.
- R5: Operations 6, 7 and 8 each send a single command cycle: 90h, 70h and FFh respectively.
- R6: Operation 9 sends 85h, column low, column high, then the data bytes. Operation 10 sends 05h, column low, column high, E0h.
- R7: Operations 2, 3, 4 and 9 send exactly `req_len` data bytes, in handshake order, taken from `din_data` when `din_valid` and `din_ready` are both high. A length of zero sends none.
- R8: An operation code of 11 to 15 is rejected, and so is a column of 2112 or more on an operation that uses the column (0–4, 9, 10). A rejected request gives `done` with `err` high on the clock after acceptance and no bus cycle at all.
- R9: For operations 0 to 5, `done` does not come before `rb_n` has been sampled high, after a guard delay that follows the confirm cycle.
- R10: After reset the bus is idle: `ce_n` and `we_n` are high, `cle` and `ale` are low, `busy` is low and `req_ready` is high. `req_ready` is low while an operation is in progress, and a request held valid meanwhile is executed afterwards.
- R11: `done` is a one-clock pulse issued with `ce_n` already high, and `err` is low for every accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_op | input | 4 | Operation code 0–10 |
| req_col | input | COL_W | Column address |
| req_row | input | ROW_W | Row (page) address |
| req_len | input | LEN_W | Number of data bytes for data-carrying operations |
| cfg_we_lo | input | TW | Write-strobe low phase in clocks (0 treated as 1) |
| cfg_we_hi | input | TW | Write-strobe high phase in clocks (0 treated as 1) |
| din_valid | input | 1 | Data byte available |
| din_ready | output | 1 | Data byte consumed on this edge when valid |
| din_data | input | 8 | Data byte |
| rb_n | input | 1 | Device ready (high) / busy (low) |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch strobe |
| ale | output | 1 | Address latch strobe |
| we_n | output | 1 | Write strobe, device latches on rising edge |
| io_out | output | 8 | Bus byte |
| io_oe | output | 1 | Bus driven by the block |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished, one-clock pulse |
| err | output | 1 | Request rejected, valid with done |

## Verification
Every operation code, including the five unused ones, is run against five columns. The columns are zero, a mid value, the last spare byte 2111, the first illegal value 2112 and the all-ones value. Together these separate a correct bound from an off-by-one and show that erase ignores the column. Data lengths of zero, one and three show that the data phase is skipped or repeated exactly. The strobe low and high settings rotate through 0 to 3, which checks the zero-means-one rule and the measured pulse width. A modelled busy pulse after every confirm opcode shows whether completion waits for ready. A back-to-back pair sent while busy checks that a held request is kept.

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq #(
  parameter int COL_W      = 12,
  parameter int ROW_W      = 16,
  parameter int LEN_W      = 12,
  parameter int TW         = 4,
  parameter int RB_GUARD   = 4,
  parameter int PAGE_BYTES = 2112
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_op,
  input  logic [COL_W-1:0] req_col,
  input  logic [ROW_W-1:0] req_row,
  input  logic [LEN_W-1:0] req_len,
  input  logic [TW-1:0]    cfg_we_lo,
  input  logic [TW-1:0]    cfg_we_hi,
  input  logic             din_valid,
  output logic             din_ready,
  input  logic [7:0]       din_data,
  input  logic             rb_n,
  output logic             ce_n,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic [7:0]       io_out,
  output logic             io_oe,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int GW = $clog2(RB_GUARD + 1);
  localparam logic [TW-1:0]    ONE_T = 1;
  localparam logic [LEN_W-1:0] ONE_L = 1;
  localparam logic [GW-1:0]    ONE_G = 1;
  localparam logic [GW-1:0]    GMAX  = GW'(RB_GUARD);
  localparam logic [3:0] ONE_I = 4'd1;

  localparam logic [3:0] OP_RD = 4'd0, OP_RDCB = 4'd1, OP_PG = 4'd2, OP_CP = 4'd3,
                         OP_CB = 4'd4, OP_ER = 4'd5, OP_ID = 4'd6, OP_ST = 4'd7,
                         OP_RS = 4'd8, OP_RI = 4'd9, OP_RO = 4'd10;

  typedef enum logic [2:0] {S_IDLE, S_STEP, S_SET, S_LOW, S_HIGH, S_WAIT} st_t;
  typedef enum logic [2:0] {K_CMD, K_ADR, K_DAT, K_WT, K_END} kind_t;

  st_t              st;
  logic [3:0]       op;
  logic [15:0]      col, row;
  logic [LEN_W-1:0] rem;
  logic [3:0]       idx;
  logic [TW-1:0]    cnt;
  logic [GW-1:0]    gcnt;

  kind_t      kind;
  logic [7:0] cbyte, abyte;
  logic [1:0] asel;

  wire [TW-1:0] lo_n = (cfg_we_lo == '0) ? ONE_T : cfg_we_lo;
  wire [TW-1:0] hi_n = (cfg_we_hi == '0) ? ONE_T : cfg_we_hi;

  wire uses_col = (req_op <= OP_CB) || (req_op == OP_RI) || (req_op == OP_RO);
  wire bad      = (req_op > OP_RO) || (uses_col && (int'(req_col) >= PAGE_BYTES));

  assign busy      = (st != S_IDLE);
  assign req_ready = (st == S_IDLE);
  assign din_ready = (st == S_STEP) && (kind == K_DAT) && (rem != '0);

  always_comb begin
    kind  = K_END;
    cbyte = 8'h00;
    asel  = idx[1:0] - 2'd1;
    case (op)
      OP_RD, OP_RDCB:
        case (idx)
          4'd0: begin kind = K_CMD; cbyte = 8'h00; end
          4'd1, 4'd2, 4'd3, 4'd4: kind = K_ADR;
          4'd5: begin kind = K_CMD; cbyte = (op == OP_RD) ? 8'h30 : 8'h35; end
          4'd6: kind = K_WT;
          default: kind = K_END;
        endcase
      OP_PG, OP_CP, OP_CB:
        case (idx)
          4'd0: begin kind = K_CMD; cbyte = (op == OP_CB) ? 8'h85 : 8'h80; end
          4'd1, 4'd2, 4'd3, 4'd4: kind = K_ADR;
          4'd5: kind = K_DAT;
          4'd6: begin kind = K_CMD; cbyte = (op == OP_CP) ? 8'h15 : 8'h10; end
          4'd7: kind = K_WT;
          default: kind = K_END;
        endcase
      OP_ER:
        case (idx)
          4'd0: begin kind = K_CMD; cbyte = 8'h60; end
          4'd1: begin kind = K_ADR; asel = 2'd2; end
          4'd2: begin kind = K_ADR; asel = 2'd3; end
          4'd3: begin kind = K_CMD; cbyte = 8'hD0; end
          4'd4: kind = K_WT;
          default: kind = K_END;
        endcase
      OP_ID, OP_ST, OP_RS:
        if (idx == 4'd0) begin
          kind  = K_CMD;
          cbyte = (op == OP_ID) ? 8'h90 : (op == OP_ST) ? 8'h70 : 8'hFF;
        end
      OP_RI, OP_RO:
        case (idx)
          4'd0: begin kind = K_CMD; cbyte = (op == OP_RI) ? 8'h85 : 8'h05; end
          4'd1, 4'd2: kind = K_ADR;
          4'd3: if (op == OP_RI) kind = K_DAT;
                else begin kind = K_CMD; cbyte = 8'hE0; end
          default: kind = K_END;
        endcase
      default: kind = K_END;
    endcase
  end

  always_comb
    case (asel)
      2'd0:    abyte = col[7:0];
      2'd1:    abyte = col[15:8];
      2'd2:    abyte = row[7:0];
      default: abyte = row[15:8];
    endcase

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= '0; col <= '0; row <= '0; rem <= '0; idx <= '0;
      cnt <= '0; gcnt <= '0; ce_n <= 1'b1; cle <= 1'b0; ale <= 1'b0;
      we_n <= 1'b1; io_out <= '0; io_oe <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (req_valid) begin
            if (bad) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              op   <= req_op;
              col  <= 16'(req_col);
              row  <= 16'(req_row);
              rem  <= req_len;
              idx  <= '0;
              ce_n <= 1'b0;
              st   <= S_STEP;
            end
          end
        S_STEP:
          case (kind)
            K_CMD, K_ADR: begin
              io_out <= (kind == K_CMD) ? cbyte : abyte;
              cle    <= (kind == K_CMD);
              ale    <= (kind == K_ADR);
              io_oe  <= 1'b1;
              st     <= S_SET;
            end
            K_DAT:
              if (rem == '0) idx <= idx + ONE_I;
              else if (din_valid) begin
                io_out <= din_data;
                cle    <= 1'b0;
                ale    <= 1'b0;
                io_oe  <= 1'b1;
                rem    <= rem - ONE_L;
                st     <= S_SET;
              end
            K_WT: begin
              cle   <= 1'b0;
              ale   <= 1'b0;
              io_oe <= 1'b0;
              gcnt  <= '0;
              st    <= S_WAIT;
            end
            default: begin
              done  <= 1'b1;
              err   <= 1'b0;
              ce_n  <= 1'b1;
              cle   <= 1'b0;
              ale   <= 1'b0;
              io_oe <= 1'b0;
              st    <= S_IDLE;
            end
          endcase
        S_SET: begin
          we_n <= 1'b0;
          cnt  <= lo_n - ONE_T;
          st   <= S_LOW;
        end
        S_LOW:
          if (cnt == '0) begin
            we_n <= 1'b1;
            cnt  <= hi_n - ONE_T;
            st   <= S_HIGH;
          end else cnt <= cnt - ONE_T;
        S_HIGH:
          if (cnt == '0) begin
            if (kind != K_DAT) idx <= idx + ONE_I;
            st <= S_STEP;
          end else cnt <= cnt - ONE_T;
        S_WAIT:
          if (gcnt < GMAX) gcnt <= gcnt + ONE_G;
          else if (rb_n) begin
            idx <= idx + ONE_I;
            st  <= S_STEP;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_we_ce_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);
  p_low_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> ($stable(io_out) && $stable(cle) && $stable(ale)));
  p_setup_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> ($stable(io_out) && $stable(cle) && $stable(ale)));
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ($stable(io_out) && $stable(cle) && $stable(ale)));
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  p_din_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> (we_n && !ce_n));
  p_reject_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (ce_n && $past(ce_n)));
  p_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !rb_n) |=> (st == S_WAIT));
  p_done_ce_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ce_n && we_n));
endmodule

// File: tb/nand_cmd_seq_test.sv
module nand_cmd_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [3:0]  req_op = '0;
  logic [11:0] req_col = '0;
  logic [15:0] req_row = '0;
  logic [11:0] req_len = '0;
  logic [3:0]  cfg_we_lo = 4'd1, cfg_we_hi = 4'd1;
  logic        din_valid = 1'b1, din_ready;
  logic [7:0]  din_data = 8'h3C;
  logic        rb_n = 1'b1;
  logic        ce_n, cle, ale, we_n, io_oe, busy, done, err;
  logic [7:0]  io_out;

  nand_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_col(req_col), .req_row(req_row), .req_len(req_len),
    .cfg_we_lo(cfg_we_lo), .cfg_we_hi(cfg_we_hi), .din_valid(din_valid),
    .din_ready(din_ready), .din_data(din_data), .rb_n(rb_n), .ce_n(ce_n),
    .cle(cle), .ale(ale), .we_n(we_n), .io_out(io_out), .io_oe(io_oe),
    .busy(busy), .done(done), .err(err));

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string rq, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", rq, got, exp);
    end
  endtask

  always @(posedge clk)
    if (din_ready && din_valid) din_data <= din_data + 8'h11;

  logic [1:0] ck [0:31];
  logic [7:0] cb [0:31];
  logic [1:0] ek [0:31];
  logic [7:0] eb [0:31];
  int ncap = 0, ne = 0, lowc = 0, exp_lo = 1, rb_cnt = 0;
  bit pwe = 1'b1, rb_seen = 1'b0, lcle, lale;
  logic [7:0] lio;

  always @(negedge clk) begin
    if (rb_cnt > 0) begin rb_n = 1'b0; rb_cnt--; end
    else rb_n = 1'b1;
    if (!we_n) begin
      lowc++;
      lcle = cle; lale = ale; lio = io_out;
      if (ce_n) chk(1'b0, "R1 ce_n during strobe", 1, 0);
    end else if (!pwe) begin
      chk(lowc == exp_lo, "R1 strobe width", lowc, exp_lo);
      if (lcle && lale) chk(1'b0, "R2 cle and ale together", 1, 0);
      if (ncap < 32) begin
        ck[ncap] = lcle ? 2'd0 : (lale ? 2'd1 : 2'd2);
        cb[ncap] = lio;
      end
      ncap++;
      if (lcle && (lio == 8'h30 || lio == 8'h35 || lio == 8'h10 ||
                   lio == 8'h15 || lio == 8'hD0)) begin
        rb_cnt  = 7;
        rb_seen = 1'b1;
      end
      lowc = 0;
    end
    pwe = we_n;
  end

  task automatic push(input logic [1:0] k, input logic [7:0] b);
    ek[ne] = k; eb[ne] = b; ne++;
  endtask

  task automatic run_op(input int op, input int col, input int row, input int len,
                        input int lo, input int hi);
    logic [7:0] cl, ch, rl, rh, base;
    bit bad, waits, usecol;
    string rq;
    int t;
    @(negedge clk); #2;
    cfg_we_lo = 4'(lo); cfg_we_hi = 4'(hi);
    exp_lo = (lo == 0) ? 1 : lo;
    ncap = 0; ne = 0; rb_seen = 1'b0;
    base = din_data;
    cl = 8'(col); ch = 8'(col >> 8); rl = 8'(row); rh = 8'(row >> 8);
    usecol = (op <= 4) || op == 9 || op == 10;
    bad = (op > 10) || (usecol && col >= 2112);
    waits = (op <= 5);
    rq = (op <= 4) ? "R3" : (op == 5) ? "R4" : (op <= 8) ? "R5" : "R6";
    case (op)
      0, 1: begin
        push(0, 8'h00); push(1, cl); push(1, ch); push(1, rl); push(1, rh);
        push(0, (op == 0) ? 8'h30 : 8'h35);
      end
      2, 3, 4: begin
        push(0, (op == 4) ? 8'h85 : 8'h80);
        push(1, cl); push(1, ch); push(1, rl); push(1, rh);
        for (int k = 0; k < len; k++) push(2, base + 8'(8'h11 * k));
        push(0, (op == 3) ? 8'h15 : 8'h10);
      end
      5: begin push(0, 8'h60); push(1, rl); push(1, rh); push(0, 8'hD0); end
      6: push(0, 8'h90);
      7: push(0, 8'h70);
      8: push(0, 8'hFF);
      9: begin
        push(0, 8'h85); push(1, cl); push(1, ch);
        for (int k = 0; k < len; k++) push(2, base + 8'(8'h11 * k));
      end
      10: begin push(0, 8'h05); push(1, cl); push(1, ch); push(0, 8'hE0); end
      default: ;
    endcase
    req_op = 4'(op); req_col = 12'(col); req_row = 16'(row); req_len = 12'(len);
    req_valid = 1'b1;
    while (!req_ready) begin @(negedge clk); #2; end
    @(negedge clk); #2;
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 3000) begin @(negedge clk); #2; t++; end
    chk(done == 1'b1, "R11 done seen", done, 1);
    chk(err == bad, "R8 err flag", err, bad);
    chk(ce_n == 1'b1, "R11 ce_n high at done", ce_n, 1);
    if (bad) chk(ncap == 0, "R8 no bus cycles on reject", ncap, 0);
    else begin
      chk(ncap == ne, (len > 0 && (op == 2 || op == 3 || op == 4 || op == 9)) ?
          "R7 cycle count" : {rq, " cycle count"}, ncap, ne);
      for (int i = 0; i < ne && i < ncap && i < 32; i++) begin
        chk(ck[i] == ek[i], "R2 cycle kind", ck[i], ek[i]);
        chk(cb[i] == eb[i], (ek[i] == 2) ? "R7 data byte" : {rq, " bus byte"}, cb[i], eb[i]);
      end
      if (waits) begin
        chk(rb_seen && rb_cnt == 0 && rb_n == 1'b1, "R9 done after ready", rb_cnt, 0);
      end
    end
    @(negedge clk); #2;
    chk(done == 1'b0, "R11 done single pulse", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(ce_n == 1'b1 && we_n == 1'b1, "R10 reset strobes", {ce_n, we_n}, 3);
    chk(cle == 1'b0 && ale == 1'b0, "R10 reset latches", {cle, ale}, 0);
    chk(busy == 1'b0 && req_ready == 1'b1, "R10 reset idle", {busy, req_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(done == 1'b0 && ce_n == 1'b1, "R10 idle after reset", {done, ce_n}, 1);

    begin
      int cols [5] = '{0, 16'h05A3, 2111, 2112, 4095};
      int k = 0;
      for (int op = 0; op < 16; op++)
        for (int c = 0; c < 5; c++)
          for (int ln = 0; ln < 4; ln += (ln == 1) ? 2 : 1) begin
            run_op(op, cols[c], 16'h1234 + (op << 8) + c * 16'h0F01, ln, k % 4, (k / 4) % 4);
            k++;
          end
    end

    @(negedge clk); #2;
    cfg_we_lo = 4'd2; cfg_we_hi = 4'd2; exp_lo = 2; ncap = 0;
    req_op = 4'd8; req_valid = 1'b1;
    @(negedge clk); #2;
    req_op = 4'd7;
    chk(busy == 1'b1 && req_ready == 1'b0, "R10 held off while busy", {busy, req_ready}, 2);
    begin
      int t = 0;
      while (!done && t < 500) begin @(negedge clk); #2; t++; end
      @(negedge clk); #2;
      req_valid = 1'b0;
      t = 0;
      while (!done && t < 500) begin @(negedge clk); #2; t++; end
    end
    chk(ncap == 2, "R10 both requests run", ncap, 2);
    chk(cb[0] == 8'hFF && cb[1] == 8'h70, "R10 request order", {cb[0], cb[1]}, 16'hFF70);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R10 watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule